// File: doc/BRIEF.md
# Round-Robin Multi-Engine Output Collector

This block collects finished blocks from several parallel transform engines and hands them, one at a time, to a single entropy encoder. Each engine owns a small output buffer of several entries. The collector keeps a table of which entries hold a finished block and which of them carries the end-of-frame mark. A write pointer chooses the one engine entry that may be filled next. A read pointer chooses the one entry that is streamed to the encoder next. Both pointers step through the engines in a fixed circular order, so blocks leave in the same order they were produced.

An engine sees its bit of `eng_ready` high and pulses its bit of `fill_req` to report a full entry. When the encoder reports idle and the entry at the read pointer is full, the collector starts a fixed-length stream. During the stream it presents the entry's coordinates and a beat counter to the output arbiter. After the last beat the entry is released and the read pointer moves on. If the released entry was marked last, a one-cycle frame-end pulse follows.

Top module: `occ_collector`

## Requirements
- R1: After reset no entry is full, `eng_ready` is 4'b0001 (engine 0 may fill slot 0), `strm_active` is 0 and `frame_end` is 0.
- R2: A fill is accepted only from the engine whose `eng_ready` bit is high. The write pointer then moves from engine 0 to engine 3 within one slot, then to the next slot index, and wraps from (engine 3, last slot) to (engine 0, slot 0).
- R3: A `fill_req` bit for an engine whose `eng_ready` bit is low is ignored: `eng_ready` does not change and no entry becomes full.
- R4: When `strm_active` is 0, `enc_idle` is 1 and the entry at the read pointer is full, `strm_active` rises on the next clock, with `strm_beat` = 0 and `strm_eng`/`strm_slot` naming that entry.
- R5: A stream lasts exactly DRAIN_BEATS (default 80) cycles. `strm_beat` counts 0 to DRAIN_BEATS-1, and `strm_eng`/`strm_slot` stay steady. `enc_idle` has no effect while a stream is active.
- R6: When a stream ends, its entry is marked empty and the read pointer advances in the same circular order as the write pointer. If the write pointer is on that entry, the engine becomes ready again on the next cycle.
- R7: No stream starts while `enc_idle` is 0, even when the entry at the read pointer is full.
- R8: `frame_end` is high for exactly the one cycle after the final beat of an entry that was filled with its `fill_last` bit set. It stays low after every other entry.
- R9: When every entry is full, all `eng_ready` bits are 0.
- R10: A fill accepted in the same cycle as the final beat of a stream takes effect together with the release of the streamed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_req | input | NUM_ENG | Per-engine pulse: the offered entry is full |
| fill_last | input | NUM_ENG | Per-engine flag sampled with fill_req: entry ends the frame |
| eng_ready | output | NUM_ENG | One-hot: the engine allowed to fill next |
| enc_idle | input | 1 | Entropy encoder is idle and may accept a block |
| strm_active | output | 1 | A block is being streamed to the encoder |
| strm_eng | output | EW | Engine of the entry being streamed |
| strm_slot | output | SW | Slot of the entry being streamed |
| strm_beat | output | BW | Beat index within the stream |
| frame_end | output | 1 | One-cycle pulse after the last-marked entry is streamed |

## Verification
Two events can land on the same clock edge: an engine fill and the end of a stream. When both happen, the table must set one entry and clear another in the same cycle, while both pointers step. The bench first fills every entry, then drains one entry so the wrapped write pointer points at a free entry. It then raises engine 0's fill request on exactly the final beat of the next stream. The result is judged at the ports: after that edge, `eng_ready` must move to engine 1, whose entry was just released. Later the refilled entry must stream out in its turn with its frame-end mark.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [0:0] {
    SQ_WAIT   = 1'b0,
    SQ_STREAM = 1'b1
  } seq_state_t;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/occ_ring_ptr.sv
module occ_ring_ptr #(
  parameter int unsigned NUM_ENG  = 4,
  parameter int unsigned NUM_SLOT = 2,
  localparam int unsigned EW = occ_pkg::idx_width(NUM_ENG),
  localparam int unsigned SW = occ_pkg::idx_width(NUM_SLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [EW-1:0] eng,
  output logic [SW-1:0] slot
);
  localparam logic [EW-1:0] ENG_MAX  = EW'(NUM_ENG - 1);
  localparam logic [SW-1:0] SLOT_MAX = SW'(NUM_SLOT - 1);

  logic [EW-1:0] eng_q, eng_n;
  logic [SW-1:0] slot_q, slot_n;

  always_comb begin
    eng_n  = eng_q;
    slot_n = slot_q;
    if (step) begin
      if (eng_q == ENG_MAX) begin
        eng_n  = '0;
        slot_n = (slot_q == SLOT_MAX) ? '0 : slot_q + 1'b1;
      end else begin
        eng_n = eng_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_q  <= '0;
      slot_q <= '0;
    end else if (step) begin
      eng_q  <= eng_n;
      slot_q <= slot_n;
    end
  end

  assign eng  = eng_q;
  assign slot = slot_q;
endmodule

// File: rtl/occ_status_table.sv
module occ_status_table #(
  parameter int unsigned NUM_ENG  = 4,
  parameter int unsigned NUM_SLOT = 2,
  localparam int unsigned EW = occ_pkg::idx_width(NUM_ENG),
  localparam int unsigned SW = occ_pkg::idx_width(NUM_SLOT)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               set_en,
  input  logic [EW-1:0]                      set_eng,
  input  logic [SW-1:0]                      set_slot,
  input  logic                               set_last,
  input  logic                               clr_en,
  input  logic [EW-1:0]                      clr_eng,
  input  logic [SW-1:0]                      clr_slot,
  output logic [NUM_SLOT-1:0][NUM_ENG-1:0]   full,
  output logic [NUM_SLOT-1:0][NUM_ENG-1:0]   last
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      logic hit_set, hit_clr;
      logic full_q, full_n, last_q, last_n;

      assign hit_set = set_en && (set_eng == EW'(e)) && (set_slot == SW'(s));
      assign hit_clr = clr_en && (clr_eng == EW'(e)) && (clr_slot == SW'(s));

      always_comb begin
        full_n = full_q;
        last_n = last_q;
        if (hit_set) begin
          full_n = 1'b1;
          last_n = set_last;
        end else if (hit_clr) begin
          full_n = 1'b0;
          last_n = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          last_q <= 1'b0;
        end else if (hit_set || hit_clr) begin
          full_q <= full_n;
          last_q <= last_n;
        end
      end

      assign full[s][e] = full_q;
      assign last[s][e] = last_q;
    end
  end
endmodule

// File: rtl/occ_drain_seq.sv
module occ_drain_seq #(
  parameter int unsigned DRAIN_BEATS = 80,
  localparam int unsigned BW = occ_pkg::idx_width(DRAIN_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tail_full,
  input  logic          tail_last,
  input  logic          enc_idle,
  output logic          active,
  output logic [BW-1:0] beat,
  output logic          done,
  output logic          frame_end
);
  import occ_pkg::*;

  localparam logic [BW-1:0] BEAT_MAX = BW'(DRAIN_BEATS - 1);

  seq_state_t    st_q, st_n;
  logic [BW-1:0] beat_q, beat_n;
  logic          fe_q, fe_n;
  logic          run_en;

  always_comb begin
    st_n   = st_q;
    beat_n = beat_q;
    done   = 1'b0;
    unique case (st_q)
      SQ_WAIT: begin
        if (tail_full && enc_idle) begin
          st_n   = SQ_STREAM;
          beat_n = '0;
        end
      end
      SQ_STREAM: begin
        if (beat_q == BEAT_MAX) begin
          st_n = SQ_WAIT;
          done = 1'b1;
        end else begin
          beat_n = beat_q + 1'b1;
        end
      end
      default: st_n = SQ_WAIT;
    endcase
    fe_n = done && tail_last;
  end

  assign run_en = (st_q == SQ_STREAM) || (tail_full && enc_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_WAIT;
      beat_q <= '0;
    end else if (run_en) begin
      st_q   <= st_n;
      beat_q <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fe_q <= 1'b0;
    else        fe_q <= fe_n;
  end

  assign active    = (st_q == SQ_STREAM);
  assign beat      = beat_q;
  assign frame_end = fe_q;
endmodule

// File: rtl/occ_collector.sv
module occ_collector #(
  parameter int unsigned NUM_ENG     = 4,
  parameter int unsigned NUM_SLOT    = 2,
  parameter int unsigned DRAIN_BEATS = 80,
  localparam int unsigned EW = occ_pkg::idx_width(NUM_ENG),
  localparam int unsigned SW = occ_pkg::idx_width(NUM_SLOT),
  localparam int unsigned BW = occ_pkg::idx_width(DRAIN_BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENG-1:0] fill_req,
  input  logic [NUM_ENG-1:0] fill_last,
  output logic [NUM_ENG-1:0] eng_ready,
  input  logic               enc_idle,
  output logic               strm_active,
  output logic [EW-1:0]      strm_eng,
  output logic [SW-1:0]      strm_slot,
  output logic [BW-1:0]      strm_beat,
  output logic               frame_end
);
  logic [EW-1:0] head_eng, tail_eng;
  logic [SW-1:0] head_slot, tail_slot;
  logic [NUM_SLOT-1:0][NUM_ENG-1:0] full, last;
  logic head_full, tail_full, tail_last;
  logic accept, done;

  assign head_full = full[head_slot][head_eng];
  assign tail_full = full[tail_slot][tail_eng];
  assign tail_last = last[tail_slot][tail_eng];

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_rdy
    assign eng_ready[e] = (head_eng == EW'(e)) && !head_full;
  end

  assign accept = |(fill_req & eng_ready);

  occ_ring_ptr #(.NUM_ENG(NUM_ENG), .NUM_SLOT(NUM_SLOT)) u_head (
    .clk(clk), .rst_n(rst_n), .step(accept), .eng(head_eng), .slot(head_slot)
  );

  occ_ring_ptr #(.NUM_ENG(NUM_ENG), .NUM_SLOT(NUM_SLOT)) u_tail (
    .clk(clk), .rst_n(rst_n), .step(done), .eng(tail_eng), .slot(tail_slot)
  );

  occ_status_table #(.NUM_ENG(NUM_ENG), .NUM_SLOT(NUM_SLOT)) u_table (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept), .set_eng(head_eng), .set_slot(head_slot),
    .set_last(fill_last[head_eng]),
    .clr_en(done), .clr_eng(tail_eng), .clr_slot(tail_slot),
    .full(full), .last(last)
  );

  occ_drain_seq #(.DRAIN_BEATS(DRAIN_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tail_full(tail_full), .tail_last(tail_last), .enc_idle(enc_idle),
    .active(strm_active), .beat(strm_beat), .done(done), .frame_end(frame_end)
  );

  assign strm_eng  = tail_eng;
  assign strm_slot = tail_slot;
endmodule

// File: rtl/occ_collector_chk.sv
module occ_collector_chk #(
  parameter int unsigned NUM_ENG     = 4,
  parameter int unsigned DRAIN_BEATS = 80,
  parameter int unsigned EW = 2,
  parameter int unsigned SW = 1,
  parameter int unsigned BW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ENG-1:0] eng_ready,
  input logic               enc_idle,
  input logic               strm_active,
  input logic [EW-1:0]      strm_eng,
  input logic [SW-1:0]      strm_slot,
  input logic [BW-1:0]      strm_beat,
  input logic               frame_end
);
  localparam logic [BW-1:0] BEAT_MAX = BW'(DRAIN_BEATS - 1);

  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_ready));

  p_start_beat0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strm_active) |-> strm_beat == '0);

  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_active && strm_beat != BEAT_MAX) |=>
      (strm_active && strm_beat == $past(strm_beat) + 1'b1));

  p_entry_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_active && $past(strm_active)) |-> ($stable(strm_eng) && $stable(strm_slot)));

  p_end_after_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_active && strm_beat == BEAT_MAX) |=> !strm_active);

  p_start_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strm_active) |-> $past(enc_idle));

  p_frame_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> ($fell(strm_active) && $past(strm_beat) == BEAT_MAX));
endmodule

bind occ_collector occ_collector_chk #(
  .NUM_ENG(NUM_ENG), .DRAIN_BEATS(DRAIN_BEATS), .EW(EW), .SW(SW), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_ready(eng_ready), .enc_idle(enc_idle),
  .strm_active(strm_active), .strm_eng(strm_eng), .strm_slot(strm_slot),
  .strm_beat(strm_beat), .frame_end(frame_end)
);

// File: tb/tb_occ_collector.sv
module tb_occ_collector;
  localparam int NE = 4;
  localparam int DB = 80;

  logic          clk;
  logic          rst_n;
  logic [NE-1:0] fill_req, fill_last, eng_ready;
  logic          enc_idle, strm_active, frame_end;
  logic [1:0]    strm_eng;
  logic [0:0]    strm_slot;
  logic [6:0]    strm_beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit over  = 0;

  occ_collector dut (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_last(fill_last),
    .eng_ready(eng_ready), .enc_idle(enc_idle), .strm_active(strm_active),
    .strm_eng(strm_eng), .strm_slot(strm_slot), .strm_beat(strm_beat),
    .frame_end(frame_end)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic fill(input int e, input bit lst);
    fill_req  = NE'(1 << e);
    fill_last = lst ? NE'(1 << e) : '0;
    @(negedge clk);
    fill_req  = '0;
    fill_last = '0;
  endtask

  task automatic t_reset();
    chk("R1 eng_ready", int'(eng_ready), 1);
    chk("R1 strm_active", int'(strm_active), 0);
    chk("R1 frame_end", int'(frame_end), 0);
  endtask

  task automatic t_ignore();
    fill(2, 1'b0);
    chk("R3 ready unchanged", int'(eng_ready), 1);
    fill(3, 1'b1);
    chk("R3 ready unchanged again", int'(eng_ready), 1);
  endtask

  task automatic t_fill_all();
    for (int k = 0; k < 8; k++) begin
      chk("R2 write order", int'(eng_ready), 1 << (k % NE));
      fill(k % NE, k == 7);
    end
    chk("R9 all full none ready", int'(eng_ready), 0);
  endtask

  task automatic t_hold_busy();
    enc_idle = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 no start without idle", int'(strm_active), 0);
    end
  endtask

  task automatic drain_one(input int e, input int s, input bit lst, input int fe);
    enc_idle = 1'b1;
    @(negedge clk);
    chk("R4 stream start", int'(strm_active), 1);
    chk("R4 stream engine", int'(strm_eng), e);
    chk("R4 stream slot", int'(strm_slot), s);
    chk("R4 first beat", int'(strm_beat), 0);
    enc_idle = 1'b0;
    for (int b = 1; b < DB; b++) begin
      if (b == 10) enc_idle = 1'b1;
      if (b == 20) enc_idle = 1'b0;
      @(negedge clk);
      chk("R5 beat count", int'(strm_beat), b);
      if (b == 15) chk("R5 idle ignored", int'(strm_active), 1);
    end
    chk("R5 engine steady", int'(strm_eng), e);
    if (fe >= 0) fill(fe, 1'b1);
    else @(negedge clk);
    chk("R5 stream length", int'(strm_active), 0);
    chk("R8 frame_end", int'(frame_end), int'(lst));
    @(negedge clk);
    chk("R8 frame_end one cycle", int'(frame_end), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    fill_req = '0;
    fill_last = '0;
    enc_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_fill_all();
    t_hold_busy();
    drain_one(0, 0, 1'b0, -1);
    chk("R6 released entry ready", int'(eng_ready), 1);
    drain_one(1, 0, 1'b0, 0);
    chk("R10 fill and release together", int'(eng_ready), 2);
    drain_one(2, 0, 1'b0, -1);
    drain_one(3, 0, 1'b0, -1);
    drain_one(0, 1, 1'b0, -1);
    drain_one(1, 1, 1'b0, -1);
    drain_one(2, 1, 1'b0, -1);
    drain_one(3, 1, 1'b1, -1);
    chk("R6 read pointer wrapped", int'(eng_ready), 2);
    drain_one(0, 0, 1'b1, -1);
    enc_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 no start when tail empty", int'(strm_active), 0);
    chk("R6 final ready", int'(eng_ready), 2);
    summary();
  end
endmodule